// File: doc/BRIEF.md
# Predicated merging vector AND unit

This block is a SIMD datapath that forms the bitwise AND of two vector operands, lane by lane, under a per-byte predicate mask. The lane width is picked at run time from a 2-bit size code (bytes, halfwords, words or doublewords). The vector length is fixed when the block is built. The first operand is also the destination. Lanes that the predicate enables get the AND of the two operands. Lanes it disables keep the first operand's element unchanged, so the result can be written straight back over the first operand.

Each lane's enable comes from the predicate bit of the lowest-addressed byte of that lane. The predicate bits of the other bytes in the lane have no effect. When a valid strobe arrives, the unit captures the merged result in a register and raises its own valid flag on the next clock edge.

Top module: `vpred_and_merge`

## Requirements
- R1: The size code sets the lane width: 2'b00 gives 8 bits, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64. The vector is split into VL divided by that width lanes, and lane k covers bits k*width upward.
- R2: In an enabled lane, the result element equals the bitwise AND of the matching elements of vec_a and vec_b.
- R3: In a disabled lane, the result element equals the vec_a element, bit for bit.
- R4: A lane is enabled exactly when pred_mask bit (k*width/8) is 1, where k is the lane index. The predicate bits of the other bytes inside that lane have no effect on the result.
- R5: When no lane is enabled, vec_b has no effect and the whole result equals vec_a.
- R6: out_valid is 1 in the cycle after a clock edge that samples in_valid high, and 0 after an edge that samples in_valid low. out_vec then carries the result for the inputs sampled at that edge.
- R7: A clock edge with rst high clears out_valid to 0 and out_vec to all zeros.
- R8: When in_valid is sampled low, out_vec holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operands are valid this cycle |
| elem_code | input | 2 | Lane width code (00 byte, 01 half, 10 word, 11 double) |
| vec_a | input | VL | First operand, also the destination |
| vec_b | input | VL | Second operand |
| pred_mask | input | VL/8 | Predicate, one bit per byte of the vector |
| out_valid | output | 1 | Registered result is valid |
| out_vec | output | VL | Registered merged result |

## Verification
Every result is due exactly one clock edge after the edge that samples in_valid high. The bench drives inputs on the falling edge and samples out_valid and out_vec on the next falling edge, after the single register stage has loaded. The hold and idle checks sample one falling edge later, with in_valid low, so they see the cycle after the strobe. The reset check samples on the falling edge after a rising edge that had rst high and in_valid high together.

// File: rtl/vand_pkg.sv
package vand_pkg;

  // Lane width selector carried on elem_code
  typedef enum logic [1:0] {
    LANE_B8  = 2'b00,
    LANE_B16 = 2'b01,
    LANE_B32 = 2'b10,
    LANE_B64 = 2'b11
  } lane_code_e;

  localparam int NUM_CODES = 4;

  // bytes per lane for a given code index
  function automatic int lane_bytes(input int code);
    return 1 << code;
  endfunction

endpackage

// File: rtl/vand_lane_enable.sv
// Expands the per-byte predicate into a per-byte enable for the chosen lane
// width: each byte follows the predicate bit of its lane's lowest byte.
module vand_lane_enable #(
  parameter int PW = 32
) (
  input  logic [1:0]    elem_code,
  input  logic [PW-1:0] pred_mask,
  output logic [PW-1:0] byte_en,
  output logic          any_en
);
  import vand_pkg::*;

  logic [PW-1:0] en_by_code [NUM_CODES];

  for (genvar c = 0; c < NUM_CODES; c++) begin : g_code
    for (genvar i = 0; i < PW; i++) begin : g_byte
      localparam int LEAD = (i / lane_bytes(c)) * lane_bytes(c);
      assign en_by_code[c][i] = pred_mask[LEAD];
    end
  end

  always_comb begin
    unique case (lane_code_e'(elem_code))
      LANE_B8:  byte_en = en_by_code[0];
      LANE_B16: byte_en = en_by_code[1];
      LANE_B32: byte_en = en_by_code[2];
      LANE_B64: byte_en = en_by_code[3];
      default:  byte_en = '0;
    endcase
  end

  assign any_en = |byte_en;

endmodule

// File: rtl/vand_merge_core.sv
// Byte-sliced AND with merge: enabled bytes take a & b, others keep a.
module vand_merge_core #(
  parameter int VL = 256,
  localparam int PW = VL / 8
) (
  input  logic [VL-1:0] vec_a,
  input  logic [VL-1:0] vec_b,
  input  logic [PW-1:0] byte_en,
  input  logic          any_en,
  output logic [VL-1:0] merged
);
  logic [VL-1:0] b_eff;

  // second operand forced to zero when nothing is enabled
  assign b_eff = any_en ? vec_b : '0;

  for (genvar i = 0; i < PW; i++) begin : g_slice
    assign merged[8*i +: 8] = byte_en[i] ? (vec_a[8*i +: 8] & b_eff[8*i +: 8])
                                         : vec_a[8*i +: 8];
  end

endmodule

// File: rtl/vpred_and_merge.sv
// Top: predicated merging vector AND with one register stage.
// VL must be a multiple of 128 and no larger than 2048.
module vpred_and_merge #(
  parameter int VL = 256,
  localparam int PW = VL / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [1:0]    elem_code,
  input  logic [VL-1:0] vec_a,
  input  logic [VL-1:0] vec_b,
  input  logic [PW-1:0] pred_mask,
  output logic          out_valid,
  output logic [VL-1:0] out_vec
);
  logic [PW-1:0] byte_en;
  logic          any_en;
  logic [VL-1:0] merged;

  vand_lane_enable #(.PW(PW)) i_enable (
    .elem_code (elem_code),
    .pred_mask (pred_mask),
    .byte_en   (byte_en),
    .any_en    (any_en)
  );

  vand_merge_core #(.VL(VL)) i_core (
    .vec_a   (vec_a),
    .vec_b   (vec_b),
    .byte_en (byte_en),
    .any_en  (any_en),
    .merged  (merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_vec   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_vec <= merged;
    end
  end

endmodule

// File: rtl/vpred_and_merge_chk.sv
module vpred_and_merge_chk #(
  parameter int VL = 256,
  localparam int PW = VL / 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [1:0]    elem_code,
  input logic [VL-1:0] vec_a,
  input logic [VL-1:0] vec_b,
  input logic [PW-1:0] pred_mask,
  input logic          out_valid,
  input logic [VL-1:0] out_vec
);

  // R6 valid timing
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r6_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R7 reset clears outputs
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && out_vec == '0));

  // R8 hold while idle
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_vec));

  // R2 R3 result never sets a bit absent from vec_a
  a_r3_no_new_ones: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((out_vec & ~$past(vec_a)) == '0));

  // R1 R2 R3 byte lanes
  for (genvar i = 0; i < PW; i++) begin : g_b8
    a_r2_byte_active: assert property (@(posedge clk) disable iff (rst)
      (in_valid && elem_code == 2'b00 && pred_mask[i]) |=>
        out_vec[8*i +: 8] == ($past(vec_a[8*i +: 8]) & $past(vec_b[8*i +: 8])));
    a_r3_byte_inactive: assert property (@(posedge clk) disable iff (rst)
      (in_valid && elem_code == 2'b00 && !pred_mask[i]) |=>
        out_vec[8*i +: 8] == $past(vec_a[8*i +: 8]));
  end

  // R4 doubleword lanes follow only their lowest byte's predicate bit
  for (genvar k = 0; k < VL / 64; k++) begin : g_b64
    a_r4_dword_lead_off: assert property (@(posedge clk) disable iff (rst)
      (in_valid && elem_code == 2'b11 && !pred_mask[8*k]) |=>
        out_vec[64*k +: 64] == $past(vec_a[64*k +: 64]));
  end

  // R5 nothing enabled leaves vec_a intact
  a_r5_all_off: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pred_mask == '0) |=> out_vec == $past(vec_a));

endmodule

bind vpred_and_merge vpred_and_merge_chk #(.VL(VL)) i_chk (.*);

// File: tb/test_vpred_and_merge.sv
module test_vpred_and_merge;
  localparam int VL = 256;
  localparam int PW = VL / 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [1:0]    elem_code = 2'b00;
  logic [VL-1:0] vec_a = '0;
  logic [VL-1:0] vec_b = '0;
  logic [PW-1:0] pred_mask = '0;
  logic          out_valid;
  logic [VL-1:0] out_vec;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  vpred_and_merge #(.VL(VL)) i_vpred_and_merge (.*);

  function automatic logic [VL-1:0] rand_vec();
    logic [VL-1:0] v;
    for (int w = 0; w < VL / 32; w++) v[32*w +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [PW-1:0] rand_pred();
    logic [PW-1:0] p;
    for (int w = 0; w < PW; w++) p[w] = 1'($urandom & 1);
    return p;
  endfunction

  // expected result from the requirements
  function automatic logic [VL-1:0] expect_vec(input logic [1:0] c,
      input logic [VL-1:0] a, input logic [VL-1:0] b, input logic [PW-1:0] p);
    int width = 8 << c;
    int lanes = VL / width;
    logic [VL-1:0] r = a;
    logic any = 1'b0;
    for (int e = 0; e < lanes; e++) if (p[e * width / 8]) any = 1'b1;
    for (int e = 0; e < lanes; e++)
      if (p[e * width / 8])
        for (int k = 0; k < width; k++)
          r[e*width + k] = a[e*width + k] & (any ? b[e*width + k] : 1'b0);
    return r;
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check_vec(input string tag, input logic [VL-1:0] act,
                           input logic [VL-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [1:0] c,
      input logic [VL-1:0] a, input logic [VL-1:0] b, input logic [PW-1:0] p);
    logic [VL-1:0] exp;
    exp = expect_vec(c, a, b, p);
    @(negedge clk);
    elem_code = c; vec_a = a; vec_b = b; pred_mask = p; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit({tag, " R6 valid"}, out_valid, 1'b1);
    check_vec(tag, out_vec, exp);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [VL-1:0] a, b, held;
    logic [PW-1:0] p;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_bit("R7 reset valid", out_valid, 1'b0);
    check_vec("R7 reset data", out_vec, '0);
    rst = 1'b0;

    // all lanes enabled, every code: plain AND (R1 R2)
    for (int c = 0; c < 4; c++) begin
      a = rand_vec(); b = rand_vec();
      apply($sformatf("R2 all-on code %0d", c), 2'(c), a, b, '1);
      check_vec("R2 all-on value", out_vec, a & b);
    end

    // nothing enabled: result is vec_a (R5 R3)
    for (int c = 0; c < 4; c++) begin
      a = rand_vec();
      apply($sformatf("R5 all-off code %0d", c), 2'(c), a, '0, '0);
      check_vec("R5 all-off value", out_vec, a);
    end

    // R4: only non-lead bytes enabled in doublewords -> no lane active
    p = '1;
    for (int k = 0; k < VL / 64; k++) p[8*k] = 1'b0;
    a = rand_vec(); b = rand_vec();
    apply("R4 dword non-lead bits", 2'b11, a, b, p);
    check_vec("R4 dword keeps a", out_vec, a);

    // R4: only lead bytes enabled in words -> all lanes active
    p = '0;
    for (int k = 0; k < VL / 32; k++) p[4*k] = 1'b1;
    a = rand_vec(); b = rand_vec();
    apply("R4 word lead bits only", 2'b10, a, b, p);
    check_vec("R4 word full and", out_vec, a & b);

    // R1 one halfword lane enabled: lane 3 leads at byte 6
    p = '0; p[6] = 1'b1;
    a = '1; b = '0;
    apply("R1 half lane 3", 2'b01, a, b, p);

    // R8 hold and R6 idle
    held = out_vec;
    @(negedge clk);
    check_bit("R6 idle valid", out_valid, 1'b0);
    vec_a = rand_vec(); vec_b = rand_vec(); pred_mask = '1;
    @(negedge clk);
    check_vec("R8 hold", out_vec, held);

    // random mix (R1 R2 R3)
    for (int c = 0; c < 4; c++)
      for (int t = 0; t < 150; t++)
        apply($sformatf("R3 random code %0d", c), 2'(c), rand_vec(),
              rand_vec(), rand_pred());

    // R7 reset wins over a valid strobe
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; vec_a = '1; vec_b = '1; pred_mask = '1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b0;
    check_bit("R7 reset with strobe", out_valid, 1'b0);
    check_vec("R7 reset with strobe data", out_vec, '0);

    finish_run();
  end

endmodule